// File: doc/BRIEF.md
# Variable-Length Bit Accumulator

This block packs a stream of bit fragments of varying size into fixed-width blocks for a downstream processing stage. Each input beat carries a 64-bit data word together with a count of how many low-order bits of that word are valid. The block appends those bits at its current fill offset inside a 1024-bit block register. Bit 0 of the block holds the first bit collected, and the bits of each fragment keep their order, lowest data bit first.

A block is handed downstream in two cases: when it holds 1024 bits, or when a beat flagged as the end of a message has been absorbed. A fragment that runs past the block boundary completes the current block. Its leftover bits are kept and open the next block. While a block waits for the consumer, the input side is stalled. A message may span many blocks. Its final block carries a flag and its exact bit count, and its unused upper bits read as zero.

Top module: `bitacc_top`

## Requirements
- R1: While reset is high, and during the first cycle after it falls, `in_ready` and `out_valid` are low. The first block after reset has no bits other than those written since.
- R2: Accepted fragment bits are placed in arrival order. The first bit of a block is at bit 0, and data bit i of a beat lands at (fill offset + i).
- R3: Data bits at positions at or above `in_len` have no effect on any emitted block.
- R4: An `in_len` value above 64 is treated as 64.
- R5: Once 1024 bits have been collected, the block is presented with `out_count` = 1024.
- R6: Bits of a fragment that do not fit in the current block start the next block, at bit 0 upward, in order.
- R7: A beat with `in_last` = 1 that leaves the block short of 1024 bits causes a block with `out_count` equal to the bits held, `out_last` = 1, and all bits at or above `out_count` zero.
- R8: A beat with `in_last` = 1 and `in_len` = 0 flushes the pending bits. With nothing pending, it yields a block with `out_count` = 0 and `out_last` = 1.
- R9: While `out_valid` is high, `in_ready` is low, and `out_block`, `out_count` and `out_last` stay stable until `out_ready` is high.
- R10: A last beat that crosses the boundary yields a full block with `out_last` = 0, then a block holding the remainder with `out_last` = 1. Every block with `out_last` = 0 is full.
- R11: `out_valid` rises in the cycle after the beat that completes a block or ends a message. After `out_ready`, `in_ready` returns in the next cycle, unless a remainder block is still owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take an input beat |
| in_data | input | 64 | Fragment bits, valid ones in the low positions |
| in_len | input | 7 | Number of valid fragment bits (0 to 64) |
| in_last | input | 1 | Beat ends the current message |
| out_valid | output | 1 | Completed block presented |
| out_ready | input | 1 | Consumer takes the block |
| out_block | output | 1024 | Collected block, first bit at bit 0 |
| out_count | output | 11 | Number of meaningful bits in the block |
| out_last | output | 1 | Block closes the message |

## Verification
Messages built from full 64-bit beats show whether bits are placed at the right offsets with no gaps. Random lengths from 0 to 64, with random data above the valid count, separate correct masking from leaking of stray bits, and show whether the fill offset advances by odd amounts. Targeted messages tell the boundary cases apart: a message of exactly one block, a last beat that straddles the boundary, a short message flushed with an empty last beat, an empty message, and oversized length values. Random back-pressure on the output checks that the input stalls while a block is held and that the held block does not change.

// File: rtl/bitacc_pkg.sv
package bitacc_pkg;

    localparam int unsigned DEF_BLK_W  = 1024;
    localparam int unsigned DEF_FRAG_W = 64;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_FILL  = 2'd1,
        ST_HOLD  = 2'd2
    } acc_state_e;

    // Bookkeeping carried alongside a presented block.
    typedef struct packed {
        logic last;       // presented block closes the message
        logic owe_tail;   // a remainder block must follow this one
    } blk_flags_t;

endpackage

// File: rtl/bitacc_mask.sv
module bitacc_mask #(
    parameter int unsigned FRAG_W = 64,
    parameter int unsigned LEN_W  = $clog2(FRAG_W + 1)
) (
    input  logic [FRAG_W-1:0] data_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic [FRAG_W-1:0] frag_o,
    output logic [LEN_W-1:0]  eff_len_o
);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(FRAG_W);

    genvar gi;
    generate
        for (gi = 0; gi < FRAG_W; gi++) begin : g_bit
            assign frag_o[gi] = data_i[gi] & (len_i > LEN_W'(gi));
        end
    endgenerate

    assign eff_len_o = (len_i > LEN_MAX) ? LEN_MAX : len_i;
endmodule

// File: rtl/bitacc_place.sv
module bitacc_place #(
    parameter int unsigned BLK_W  = 1024,
    parameter int unsigned FRAG_W = 64,
    parameter int unsigned POS_W  = $clog2(BLK_W + 1)
) (
    input  logic [BLK_W-1:0]  blk_i,
    input  logic [FRAG_W-1:0] frag_i,
    input  logic [POS_W-1:0]  pos_i,
    output logic [BLK_W-1:0]  blk_o,
    output logic [FRAG_W-1:0] spill_o
);
    localparam int unsigned OFF_W = $clog2(FRAG_W);
    localparam logic [POS_W-1:0] TAIL_BASE = POS_W'(BLK_W - FRAG_W);

    logic [BLK_W-1:0]    frag_ext;
    logic [POS_W-1:0]    rel_pos;
    logic [OFF_W-1:0]    off;
    logic [2*FRAG_W-1:0] wide;

    // Place the fragment at the fill offset; bits past the top fall off.
    assign frag_ext = BLK_W'(frag_i);
    assign blk_o    = blk_i | (frag_ext << pos_i);

    // Overflow can occur only when the offset lies in the top FRAG_W bits,
    // so a narrow 2*FRAG_W shifter recovers the bits that fell off.
    assign rel_pos = pos_i - TAIL_BASE;
    assign off     = rel_pos[OFF_W-1:0];
    assign wide    = {{FRAG_W{1'b0}}, frag_i} << off;
    assign spill_o = wide[2*FRAG_W-1:FRAG_W];
endmodule

// File: rtl/bitacc_top.sv
module bitacc_top
    import bitacc_pkg::*;
#(
    parameter int unsigned BLK_W  = DEF_BLK_W,
    parameter int unsigned FRAG_W = DEF_FRAG_W,
    parameter int unsigned LEN_W  = $clog2(FRAG_W + 1),
    parameter int unsigned POS_W  = $clog2(BLK_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [FRAG_W-1:0] in_data,
    input  logic [LEN_W-1:0]  in_len,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BLK_W-1:0]  out_block,
    output logic [POS_W-1:0]  out_count,
    output logic              out_last
);
    localparam logic [POS_W:0] BLK_SUM = (POS_W+1)'(BLK_W);

    acc_state_e          state_q;
    logic [BLK_W-1:0]    blk_q;
    logic [POS_W-1:0]    pos_q;
    logic [FRAG_W-1:0]   spill_q;
    logic [LEN_W-1:0]    spill_len_q;
    logic [POS_W-1:0]    cnt_q;
    blk_flags_t          flags_q;

    logic [FRAG_W-1:0]   frag;
    logic [LEN_W-1:0]    eff_len;
    logic [BLK_W-1:0]    merged;
    logic [FRAG_W-1:0]   spill;
    logic [POS_W:0]      sum;
    logic [POS_W:0]      over;
    logic                full;

    bitacc_mask #(.FRAG_W(FRAG_W), .LEN_W(LEN_W)) u_mask (
        .data_i    (in_data),
        .len_i     (in_len),
        .frag_o    (frag),
        .eff_len_o (eff_len)
    );

    bitacc_place #(.BLK_W(BLK_W), .FRAG_W(FRAG_W), .POS_W(POS_W)) u_place (
        .blk_i   (blk_q),
        .frag_i  (frag),
        .pos_i   (pos_q),
        .blk_o   (merged),
        .spill_o (spill)
    );

    assign sum  = {1'b0, pos_q} + (POS_W+1)'(eff_len);
    assign full = (sum >= BLK_SUM);
    assign over = sum - BLK_SUM;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_CLEAR;
            blk_q       <= '0;
            pos_q       <= '0;
            spill_q     <= '0;
            spill_len_q <= '0;
            cnt_q       <= '0;
            flags_q     <= '0;
        end else begin
            case (state_q)
                ST_CLEAR: begin
                    blk_q   <= '0;
                    pos_q   <= '0;
                    state_q <= ST_FILL;
                end
                ST_FILL: begin
                    if (in_valid) begin
                        blk_q <= merged;
                        if (full) begin
                            state_q          <= ST_HOLD;
                            cnt_q            <= POS_W'(BLK_W);
                            spill_q          <= spill;
                            spill_len_q      <= LEN_W'(over);
                            flags_q.last     <= in_last && (over == '0);
                            flags_q.owe_tail <= in_last && (over != '0);
                        end else if (in_last) begin
                            state_q          <= ST_HOLD;
                            cnt_q            <= sum[POS_W-1:0];
                            spill_q          <= '0;
                            spill_len_q      <= '0;
                            flags_q.last     <= 1'b1;
                            flags_q.owe_tail <= 1'b0;
                        end else begin
                            pos_q <= sum[POS_W-1:0];
                        end
                    end
                end
                ST_HOLD: begin
                    if (out_ready) begin
                        blk_q       <= BLK_W'(spill_q);
                        pos_q       <= POS_W'(spill_len_q);
                        spill_q     <= '0;
                        spill_len_q <= '0;
                        if (flags_q.owe_tail) begin
                            cnt_q            <= POS_W'(spill_len_q);
                            flags_q.last     <= 1'b1;
                            flags_q.owe_tail <= 1'b0;
                        end else begin
                            state_q <= ST_FILL;
                        end
                    end
                end
                default: state_q <= ST_CLEAR;
            endcase
        end
    end

    assign in_ready  = (state_q == ST_FILL);
    assign out_valid = (state_q == ST_HOLD);
    assign out_block = blk_q;
    assign out_count = cnt_q;
    assign out_last  = flags_q.last;
endmodule

// File: rtl/bitacc_chk.sv
module bitacc_chk #(
    parameter int unsigned BLK_W  = 1024,
    parameter int unsigned FRAG_W = 64,
    parameter int unsigned LEN_W  = $clog2(FRAG_W + 1),
    parameter int unsigned POS_W  = $clog2(BLK_W + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_last,
    input logic              out_valid,
    input logic              out_ready,
    input logic [BLK_W-1:0]  out_block,
    input logic [POS_W-1:0]  out_count,
    input logic              out_last
);
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!in_ready && !out_valid));

    p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_count <= POS_W'(BLK_W)));

    p_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_block >> out_count) == '0));

    p_no_accept_hold_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    p_hold_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_block) && $stable(out_count) && $stable(out_last)));

    p_partial_only_last_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |-> (out_count == POS_W'(BLK_W)));

    p_emit_after_last_r11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_last) |=> out_valid);
endmodule

bind bitacc_top bitacc_chk #(
    .BLK_W (BLK_W),
    .FRAG_W(FRAG_W),
    .LEN_W (LEN_W),
    .POS_W (POS_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_block (out_block),
    .out_count (out_count),
    .out_last  (out_last)
);

// File: tb/bitacc_top_test.sv
module bitacc_top_test;
    localparam int BLK = 1024;
    localparam int FW  = 64;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [FW-1:0]     in_data = '0;
    logic [6:0]        in_len = '0;
    logic              in_last = 1'b0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [BLK-1:0]    out_block;
    logic [10:0]       out_count;
    logic              out_last;

    bitacc_top uut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_len(in_len), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_block(out_block), .out_count(out_count), .out_last(out_last)
    );

    always #10 clk = ~clk;   // 50 MHz

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Behavioural reference: bit queue plus queue of expected blocks.
    bit             mq[$];
    logic [BLK-1:0] exp_blk[$];
    int             exp_cnt[$];
    bit             exp_last[$];

    int  blocks_seen = 0;
    int  got_cnt = -1;
    bit  got_last = 0;
    bit  accepted = 0;

    task automatic check(input bit ok, input string tag, input longint got, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, expv);
        end
    endtask

    task automatic push_block(input int n, input bit last);
        logic [BLK-1:0] b = '0;
        for (int i = 0; i < n; i++) b[i] = mq.pop_front();
        exp_blk.push_back(b);
        exp_cnt.push_back(n);
        exp_last.push_back(last);
    endtask

    task automatic model_accept(input logic [FW-1:0] d, input int len, input bit last);
        int eff = (len > FW) ? FW : len;   // R4 clamp, R3 masking
        bit closed = 0;
        for (int i = 0; i < eff; i++) mq.push_back(d[i]);
        if (mq.size() >= BLK) begin
            bit l = last && (mq.size() == BLK);
            push_block(BLK, l);
            closed = l;
        end
        if (last && !closed) push_block(mq.size(), 1'b1);
    endtask

    // One clock: evaluate handshakes on current inputs, advance, check outputs.
    task automatic step();
        bit acc = in_valid && in_ready;
        bit rel = out_valid && out_ready;
        if (rel) begin
            if (exp_blk.size() == 0) begin
                check(1'b0, "R11 unexpected block", 1, 0);
            end else begin
                check(out_block === exp_blk[0], "R2 block bits", 0, 0);
                if (out_block !== exp_blk[0])
                    $display("FAIL R2 got=%h exp=%h", out_block, exp_blk[0]);
                check(int'(out_count) == exp_cnt[0],
                      (exp_cnt[0] == BLK) ? "R5 count" : "R7 count", out_count, exp_cnt[0]);
                check(out_last == exp_last[0], "R10 last flag", out_last, exp_last[0]);
                void'(exp_blk.pop_front());
                void'(exp_cnt.pop_front());
                void'(exp_last.pop_front());
                blocks_seen++;
                got_cnt = out_count;
                got_last = out_last;
            end
        end
        if (acc) model_accept(in_data, int'(in_len), in_last);
        accepted = acc;
        @(posedge clk);
        @(negedge clk);
        check(out_valid == (exp_blk.size() > 0), "R11 out_valid", out_valid, exp_blk.size() > 0);
        check(in_ready == (exp_blk.size() == 0), "R9 in_ready", in_ready, exp_blk.size() == 0);
    endtask

    task automatic send(input logic [FW-1:0] d, input int len, input bit last);
        in_valid = 1'b1; in_data = d; in_len = 7'(len); in_last = last;
        accepted = 0;
        while (!accepted) begin
            out_ready = ($urandom % 4) != 0;
            step();
        end
        in_valid = 1'b0; in_data = {$urandom, $urandom}; in_last = 1'b0;
    endtask

    task automatic drain();
        in_valid = 1'b0;
        out_ready = 1'b1;
        while (exp_blk.size() > 0 || out_valid) step();
        out_ready = 1'b0;
        step();
    endtask

    task automatic send_msg(input int nbits, input int maxlen);
        int rem = nbits;
        if (nbits == 0) send({$urandom, $urandom}, 0, 1'b1);
        while (rem > 0) begin
            int len = $urandom_range(0, maxlen);
            if (len > rem) len = rem;
            rem -= len;
            send({$urandom, $urandom}, len, rem == 0);
        end
    endtask

    initial begin
        int base;
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!in_ready && !out_valid, "R1 during reset", in_ready, 0);
        rst = 1'b0;
        check(!in_ready && !out_valid, "R1 first cycle after reset", in_ready, 0);
        @(posedge clk); @(negedge clk);
        check(in_ready == 1'b1, "R1 ready after clear", in_ready, 1);

        // R2 R5: exactly one block from full-width beats
        base = blocks_seen;
        for (int i = 0; i < 16; i++) send({$urandom, $urandom}, 64, i == 15);
        drain();
        check(blocks_seen - base == 1 && got_cnt == BLK && got_last, "R5 single full block", got_cnt, BLK);

        // R3 R6: random lengths with garbage above len, several blocks
        send_msg(3000, 64);
        drain();
        check(got_last && got_cnt == 3000 - 2 * BLK, "R6 tail of multi-block message", got_cnt, 3000 - 2 * BLK);
        send_msg(5555, 17);
        drain();
        check(got_last && got_cnt == 5555 - 5 * BLK, "R3 odd lengths tail", got_cnt, 5555 - 5 * BLK);

        // R7: short message
        send_msg(37, 40);
        drain();
        check(got_last && got_cnt == 37, "R7 partial block", got_cnt, 37);

        // R8: zero-length last after some bits, and on an empty buffer
        send({$urandom, $urandom}, 50, 1'b0);
        send({$urandom, $urandom}, 0, 1'b1);
        drain();
        check(got_last && got_cnt == 50, "R8 flush pending", got_cnt, 50);
        base = blocks_seen;
        send({64{1'b1}}, 0, 1'b1);
        drain();
        check(blocks_seen - base == 1 && got_cnt == 0 && got_last, "R8 empty flush", got_cnt, 0);

        // R4: oversized length values behave as 64
        base = blocks_seen;
        for (int i = 0; i < 16; i++) send({$urandom, $urandom}, 100, i == 15);
        drain();
        check(blocks_seen - base == 1 && got_cnt == BLK, "R4 len clamp", got_cnt, BLK);

        // R10: last beat straddles the boundary (1000 + 50)
        base = blocks_seen;
        for (int i = 0; i < 15; i++) send({$urandom, $urandom}, 64, 1'b0);
        send({$urandom, $urandom}, 40, 1'b0);
        send({$urandom, $urandom}, 50, 1'b1);
        drain();
        check(blocks_seen - base == 2 && got_cnt == 26 && got_last, "R10 split last", got_cnt, 26);

        // R10: message ends exactly on the boundary with a partial beat
        base = blocks_seen;
        for (int i = 0; i < 15; i++) send({$urandom, $urandom}, 64, 1'b0);
        send({$urandom, $urandom}, 30, 1'b0);
        send({$urandom, $urandom}, 34, 1'b1);
        drain();
        check(blocks_seen - base == 1 && got_cnt == BLK && got_last, "R10 exact boundary", got_cnt, BLK);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired got=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule